// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one external memory cycle at a time on an 8-bit-style bus where the low address byte and the data byte share a single port and the high address byte has a port of its own. An internal requester presents a kind (code fetch, data read or data write), a full address and, for writes, a data byte. The block then works through a fixed sequence of phases: an address-latch pulse, an address hold, an optional lead gap, the strobe and a release tail. It counts every edge in whole periods of its clock, which is the base timing period of the bus.

Fetch cycles use the program-store strobe with a short lead and a short pulse. Reads and writes use the read or write strobe with a longer lead and a longer pulse. For fetch and read, the block turns the shared port around so the external device can drive it. It samples the returned byte on the last strobe-low period, just before the strobe rises. When the cycle ends, a one-period completion pulse presents that byte. For a write, the pulse presents the byte that was written.

Top module: `extbus_seq`

## Requirements
- R1: Out of reset, and whenever no cycle is running, the latch strobe is low, the three active-low strobes are high, the shared-port enable is low, `req_ready` is high and `done` is low.
- R2: The latch strobe is high for exactly ALE_W (2) periods, starting the period after the request is accepted. The shared port drives the low address with its enable high from the first latch period through HOLD_W (1) period after the latch strobe falls.
- R3: `addr_hi` carries the request's high address byte from the first latch period to the end of the cycle, and it does not change while the cycle runs.
- R4: Kind code 0 (fetch) lowers `psen_n` FETCH_LEAD (1) period after the latch strobe falls and keeps it low for FETCH_W (3) periods. `rd_n` and `wr_n` stay high throughout.
- R5: Kind code 1 (read) lowers `rd_n` DATA_LEAD (3) periods after the latch strobe falls and keeps it low for DATA_W (6) periods. `psen_n` and `wr_n` stay high throughout.
- R6: For fetch and read, the byte on `ad_in` in the last strobe-low period is the one reported, so data that is valid only from the second fetch strobe period, or only from the fourth read strobe period, is still captured.
- R7: Kind code 2 (write) lowers `wr_n` DATA_LEAD periods after the latch strobe falls and keeps it low for DATA_W periods. The write byte is driven with the enable high from the period after the address hold until WR_HOLD (1) period after `wr_n` rises, which puts it on the port at least 2 periods before `wr_n` falls.
- R8: For fetch and read, the shared-port enable is low from the end of the address hold until the cycle completes. This gives FETCH_FLOAT (1) or READ_FLOAT (2) release periods after the strobe rises.
- R9: At most one of `psen_n`, `rd_n` and `wr_n` is low in any period, and none of them is low while the latch strobe is high.
- R10: `done` is high for exactly one period, in period 1+ALE_W+lead+width+tail after the accepting edge: 8 for fetch, 14 for read and 13 for write. `done_data` then holds the captured byte for fetch and read, and the written byte for a write.
- R11: A request is accepted only when the block is idle and the kind code is 0, 1 or 2. A request raised while a cycle runs, or one with kind code 3, starts no cycle and changes neither the address nor the outcome of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base timing clock, one period per timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High while idle; a valid request is taken on this edge |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 rejected |
| req_addr | input | HI_W+DW (16) | Full cycle address, high byte on top |
| req_wdata | input | DW (8) | Byte to write |
| done | output | 1 | One-period completion pulse |
| done_data | output | DW (8) | Captured byte (fetch/read) or written byte (write) |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | HI_W (8) | High address byte, never multiplexed |
| ad_out | output | DW (8) | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | DW (8) | Shared port input value |

## Verification
The bench builds the block with its default timing parameters: a 2-period latch pulse, a 1-period hold, a 1/3/1 fetch lead/width/release and a 3/6 data lead/width with 2 release periods after a read and 1 write hold. With these values, each strobe edge, the turnaround of the shared port and the completion period all fall on exact, distinct period indices that can be checked one by one. The bench's responder drives a junk byte until the latest legal valid point in each strobe, so a capture taken one period early shows up in the reported byte.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

   typedef enum logic [1:0] {
      K_FETCH = 2'd0,
      K_READ  = 2'd1,
      K_WRITE = 2'd2
   } kind_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ALE  = 3'd1,
      PH_HOLD = 3'd2,
      PH_GAP  = 3'd3,
      PH_STRB = 3'd4,
      PH_TAIL = 3'd5
   } phase_e;

endpackage

// File: rtl/extbus_phase_fsm.sv
module extbus_phase_fsm
   import extbus_pkg::*;
#(
   parameter int ALE_W       = 2,
   parameter int HOLD_W      = 1,
   parameter int FETCH_LEAD  = 1,
   parameter int FETCH_W     = 3,
   parameter int FETCH_FLOAT = 1,
   parameter int DATA_LEAD   = 3,
   parameter int DATA_W      = 6,
   parameter int READ_FLOAT  = 2,
   parameter int WR_HOLD     = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  kind_e  start_kind,
   output phase_e phase,
   output kind_e  kind,
   output logic   capture,
   output logic   done
);

   localparam int FETCH_GAP = FETCH_LEAD - HOLD_W;
   localparam int DATA_GAP  = DATA_LEAD - HOLD_W;
   localparam int MAX_A = (ALE_W > HOLD_W) ? ALE_W : HOLD_W;
   localparam int MAX_B = (FETCH_W > DATA_W) ? FETCH_W : DATA_W;
   localparam int MAX_C = (DATA_GAP > READ_FLOAT) ? DATA_GAP : READ_FLOAT;
   localparam int MAX_D = (FETCH_FLOAT > WR_HOLD) ? FETCH_FLOAT : WR_HOLD;
   localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
   localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CW = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

   generate
      if (ALE_W < 1 || HOLD_W < 1 || FETCH_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("extbus_phase_fsm: latch, hold and strobe widths must be at least 1");
      end
      if (FETCH_FLOAT < 1 || READ_FLOAT < 1 || WR_HOLD < 1) begin : g_bad_tail
         $error("extbus_phase_fsm: every release tail must be at least 1 period");
      end
      if (FETCH_GAP < 0) begin : g_bad_fetch_lead
         $error("extbus_phase_fsm: fetch lead shorter than address hold");
      end
      if (DATA_GAP < 1) begin : g_bad_data_lead
         $error("extbus_phase_fsm: data lead must exceed hold to give write setup");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] gap_len, strb_len, tail_len;
   logic          gap_zero;

   always_comb begin
      unique case (kind)
         K_FETCH: begin
            gap_len  = CW'((FETCH_GAP > 0) ? FETCH_GAP - 1 : 0);
            gap_zero = (FETCH_GAP == 0);
            strb_len = CW'(FETCH_W - 1);
            tail_len = CW'(FETCH_FLOAT - 1);
         end
         K_READ: begin
            gap_len  = CW'(DATA_GAP - 1);
            gap_zero = 1'b0;
            strb_len = CW'(DATA_W - 1);
            tail_len = CW'(READ_FLOAT - 1);
         end
         default: begin
            gap_len  = CW'(DATA_GAP - 1);
            gap_zero = 1'b0;
            strb_len = CW'(DATA_W - 1);
            tail_len = CW'(WR_HOLD - 1);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         kind  <= K_FETCH;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase <= PH_ALE;
               kind  <= start_kind;
               cnt   <= CW'(ALE_W - 1);
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            unique case (phase)
               PH_ALE: begin
                  phase <= PH_HOLD;
                  cnt   <= CW'(HOLD_W - 1);
               end
               PH_HOLD: begin
                  if (gap_zero) begin
                     phase <= PH_STRB;
                     cnt   <= strb_len;
                  end else begin
                     phase <= PH_GAP;
                     cnt   <= gap_len;
                  end
               end
               PH_GAP: begin
                  phase <= PH_STRB;
                  cnt   <= strb_len;
               end
               PH_STRB: begin
                  phase <= PH_TAIL;
                  cnt   <= tail_len;
               end
               default: begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            endcase
         end
      end
   end

   assign capture = (phase == PH_STRB) && (cnt == '0) && (kind != K_WRITE);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(kind));

endmodule

// File: rtl/extbus_strobe_dec.sv
module extbus_strobe_dec
   import extbus_pkg::*;
(
   input  phase_e phase,
   input  kind_e  kind,
   output logic   ale,
   output logic   psen_n,
   output logic   rd_n,
   output logic   wr_n,
   output logic   drive_addr,
   output logic   drive_data
);

   logic in_strobe;
   logic data_phase;

   always_comb begin
      in_strobe  = (phase == PH_STRB);
      data_phase = (phase == PH_GAP) || (phase == PH_STRB) || (phase == PH_TAIL);
      ale        = (phase == PH_ALE);
      psen_n     = !(in_strobe && kind == K_FETCH);
      rd_n       = !(in_strobe && kind == K_READ);
      wr_n       = !(in_strobe && kind == K_WRITE);
      drive_addr = (phase == PH_ALE) || (phase == PH_HOLD);
      drive_data = data_phase && (kind == K_WRITE);
   end

endmodule

// File: rtl/extbus_port_path.sv
module extbus_port_path #(
   parameter int HI_W = 8,
   parameter int DW   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [HI_W+DW-1:0] load_addr,
   input  logic [DW-1:0]      load_wdata,
   input  logic               drive_addr,
   input  logic               drive_data,
   input  logic               capture,
   input  logic [DW-1:0]      ad_in,
   output logic [HI_W-1:0]    addr_hi,
   output logic [DW-1:0]      ad_out,
   output logic               ad_oe,
   output logic [DW-1:0]      byte_q
);

   generate
      if (HI_W < 1 || DW < 1) begin : g_bad_dims
         $error("extbus_port_path: address and data widths must be positive");
      end
   endgenerate

   logic [DW-1:0] addr_lo_q;
   logic [DW-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_hi   <= '0;
         addr_lo_q <= '0;
         wdata_q   <= '0;
         byte_q    <= '0;
      end else if (load) begin
         addr_hi   <= load_addr[HI_W+DW-1:DW];
         addr_lo_q <= load_addr[DW-1:0];
         wdata_q   <= load_wdata;
         byte_q    <= load_wdata;
      end else if (capture) begin
         byte_q    <= ad_in;
      end
   end

   always_comb begin
      ad_oe  = drive_addr || drive_data;
      ad_out = drive_data ? wdata_q : addr_lo_q;
   end

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
   import extbus_pkg::*;
#(
   parameter int HI_W        = 8,
   parameter int DW          = 8,
   parameter int ALE_W       = 2,
   parameter int HOLD_W      = 1,
   parameter int FETCH_LEAD  = 1,
   parameter int FETCH_W     = 3,
   parameter int FETCH_FLOAT = 1,
   parameter int DATA_LEAD   = 3,
   parameter int DATA_W      = 6,
   parameter int READ_FLOAT  = 2,
   parameter int WR_HOLD     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         req_kind,
   input  logic [HI_W+DW-1:0] req_addr,
   input  logic [DW-1:0]      req_wdata,
   output logic               done,
   output logic [DW-1:0]      done_data,
   output logic               ale,
   output logic               psen_n,
   output logic               rd_n,
   output logic               wr_n,
   output logic [HI_W-1:0]    addr_hi,
   output logic [DW-1:0]      ad_out,
   output logic               ad_oe,
   input  logic [DW-1:0]      ad_in
);

   phase_e phase;
   kind_e  kind;
   logic   capture;
   logic   start;
   logic   drive_addr, drive_data;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready && (req_kind != 2'd3);

   extbus_phase_fsm #(
      .ALE_W(ALE_W), .HOLD_W(HOLD_W),
      .FETCH_LEAD(FETCH_LEAD), .FETCH_W(FETCH_W), .FETCH_FLOAT(FETCH_FLOAT),
      .DATA_LEAD(DATA_LEAD), .DATA_W(DATA_W),
      .READ_FLOAT(READ_FLOAT), .WR_HOLD(WR_HOLD)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_kind (kind_e'(req_kind)),
      .phase      (phase),
      .kind       (kind),
      .capture    (capture),
      .done       (done)
   );

   extbus_strobe_dec u_dec (
      .phase      (phase),
      .kind       (kind),
      .ale        (ale),
      .psen_n     (psen_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .drive_addr (drive_addr),
      .drive_data (drive_data)
   );

   extbus_port_path #(.HI_W(HI_W), .DW(DW)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .load_addr  (req_addr),
      .load_wdata (req_wdata),
      .drive_addr (drive_addr),
      .drive_data (drive_data),
      .capture    (capture),
      .ad_in      (ad_in),
      .addr_hi    (addr_hi),
      .ad_out     (ad_out),
      .ad_oe      (ad_oe),
      .byte_q     (done_data)
   );

   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({~psen_n, ~rd_n, ~wr_n}) <= 1) && !(ale && !(psen_n && rd_n && wr_n)));

   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> ad_oe && $stable(ad_out));

   a_r3_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(addr_hi));

   a_r8_port_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!psen_n || !rd_n) |-> !ad_oe);

   a_r7_wdata_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(ad_oe) && $stable(ad_out));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !ale && psen_n && rd_n && wr_n && !ad_oe);

endmodule

// File: tb/sim_extbus_seq.sv
module sim_extbus_seq;

   localparam int ALE_W = 2, HOLD_W = 1;
   localparam int FETCH_LEAD = 1, FETCH_W = 3, FETCH_FLOAT = 1;
   localparam int DATA_LEAD = 3, DATA_W = 6, READ_FLOAT = 2, WR_HOLD = 1;
   localparam int FETCH_VALID = 2, READ_VALID = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = 2'd0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        done;
   logic [7:0]  done_data;
   logic        ale, psen_n, rd_n, wr_n;
   logic [7:0]  addr_hi, ad_out;
   logic        ad_oe;
   logic [7:0]  ad_in = 8'hEE;
   logic [7:0]  resp_val = 8'h00;
   int          lowcnt = 0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   extbus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .done_data(done_data), .ale(ale), .psen_n(psen_n),
      .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out),
      .ad_oe(ad_oe), .ad_in(ad_in)
   );

   // external device model: junk until the latest legal valid point of the strobe
   always @(negedge clk) begin
      if (!psen_n || !rd_n) begin
         lowcnt = lowcnt + 1;
         ad_in  = (lowcnt >= (!psen_n ? FETCH_VALID : READ_VALID)) ? resp_val : 8'hEE;
      end else begin
         lowcnt = 0;
         ad_in  = 8'hEE;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // vector: [33:32] kind, [31:16] address, [15:8] write byte, [7:0] device byte
   localparam logic [33:0] VEC [6] = '{
      {2'd0, 16'h1234, 8'h00, 8'hA5},
      {2'd1, 16'hBEEF, 8'h00, 8'h3C},
      {2'd2, 16'h00FF, 8'h96, 8'h00},
      {2'd0, 16'hFF00, 8'h00, 8'h5A},
      {2'd2, 16'h8001, 8'h01, 8'h00},
      {2'd1, 16'h7E81, 8'h00, 8'hFF}
   };

   task automatic run_txn(input logic [1:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] ext,
                          input bit poke_busy);
      int lead, width, tail, exp_done, addr_end;
      int ale_cnt, ale_last, s_first, s_cnt, other_cnt, done_at;
      int addr_bad, hi_bad, data_bad;
      logic [7:0] got;
      lead  = (k == 2'd0) ? FETCH_LEAD : DATA_LEAD;
      width = (k == 2'd0) ? FETCH_W : DATA_W;
      tail  = (k == 2'd0) ? FETCH_FLOAT : ((k == 2'd1) ? READ_FLOAT : WR_HOLD);
      exp_done = 1 + ALE_W + lead + width + tail;
      addr_end = ALE_W + HOLD_W;
      ale_cnt = 0; ale_last = 0; s_first = 0; s_cnt = 0; other_cnt = 0; done_at = 0;
      addr_bad = 0; hi_bad = 0; data_bad = 0; got = 8'h00;
      resp_val = ext;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 1; n <= 40; n++) begin
         logic sel, oth;
         if (poke_busy && n == 3) begin
            req_valid = 1'b1; req_kind = 2'd0; req_addr = ~a; req_wdata = ~wd;
         end else if (poke_busy && n == 5) begin
            req_valid = 1'b0;
         end
         sel = (k == 2'd0) ? !psen_n : ((k == 2'd1) ? !rd_n : !wr_n);
         oth = (k == 2'd0) ? (!rd_n || !wr_n) : ((k == 2'd1) ? (!psen_n || !wr_n) : (!psen_n || !rd_n));
         if (ale) begin ale_cnt++; ale_last = n; end
         if (sel) begin if (s_cnt == 0) s_first = n; s_cnt++; end
         if (oth) other_cnt++;
         if (addr_hi != a[15:8]) hi_bad++;
         if (n <= addr_end) begin
            if (!(ad_oe && ad_out == a[7:0])) addr_bad++;
         end else if (!done) begin
            if (k == 2'd2) begin
               if (!(ad_oe && ad_out == wd)) data_bad++;
            end else if (ad_oe) data_bad++;
         end
         if (done) begin done_at = n; got = done_data; break; end
         @(negedge clk);
      end
      check(ale_cnt == ALE_W && ale_last == ALE_W, "R2 latch width", ale_cnt, ALE_W);
      check(addr_bad == 0, "R2 address on port", addr_bad, 0);
      check(hi_bad == 0, "R3 high byte stable", hi_bad, 0);
      check(s_first == ALE_W + lead + 1,
            (k == 2'd0) ? "R4 fetch strobe start" : ((k == 2'd1) ? "R5 read strobe start" : "R7 write strobe start"),
            s_first, ALE_W + lead + 1);
      check(s_cnt == width,
            (k == 2'd0) ? "R4 fetch strobe width" : ((k == 2'd1) ? "R5 read strobe width" : "R7 write strobe width"),
            s_cnt, width);
      check(other_cnt == 0, "R9 foreign strobe", other_cnt, 0);
      check(data_bad == 0, (k == 2'd2) ? "R7 write data drive" : "R8 port release", data_bad, 0);
      check(done_at == exp_done, "R10 completion period", done_at, exp_done);
      check(got == ((k == 2'd2) ? wd : ext), (k == 2'd2) ? "R10 write echo" : "R6 captured byte",
            got, (k == 2'd2) ? wd : ext);
      @(negedge clk);
      check(!done, "R10 single pulse", done, 0);
      check(req_ready && psen_n && rd_n && wr_n && !ale && !ad_oe, "R1 idle after cycle", req_ready, 1);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!ale && psen_n && rd_n && wr_n && !ad_oe && !done && req_ready,
            "R1 reset state", {ale, psen_n, rd_n, wr_n, ad_oe, done}, 6'b011100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !ad_oe, "R1 idle after release", req_ready, 1);

      for (int i = 0; i < 6; i++)
         run_txn(VEC[i][33:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

      // R11: a fetch request raised mid-read must not disturb the read
      run_txn(2'd1, 16'hC35A, 8'h00, 8'h69, 1'b1);

      // R11: kind code 3 is rejected
      begin
         int seen;
         seen = 0;
         @(negedge clk);
         req_valid = 1'b1; req_kind = 2'd3; req_addr = 16'h4242;
         @(negedge clk);
         req_valid = 1'b0;
         for (int n = 0; n < 6; n++) begin
            if (ale || !req_ready || done || ad_oe) seen++;
            @(negedge clk);
         end
         check(seen == 0, "R11 kind 3 rejected", seen, 0);
      end

      // R1: reset in the middle of a write returns the bus to idle
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h1111; req_wdata = 8'h22;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      check(!wr_n, "R7 write strobe mid-cycle", wr_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      check(wr_n && psen_n && rd_n && !ale && !ad_oe && req_ready && addr_hi == 8'h00,
            "R1 reset mid-cycle", {wr_n, ad_oe}, 2'b10);
      rst_n = 1'b1;
      run_txn(2'd0, 16'h2468, 8'h00, 8'h81, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule